// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

This block links a sending processor to a receiving processor through a set of 32-bit doorbell channels. Each side has its own register port, word-addressed inside a 4 KB frame. The sender only raises bits in a channel's shared status word. The receiver only lowers them, and it can hide bits behind a per-channel mask. A channel is active for the receiver when any of its unmasked bits is set. The active channels drive a receiver channel interrupt, and they are also packed into a combined status array that has its own enable and interrupt.

Before the sender uses the channels, it raises an access request. It waits until the access-ready flag follows the request, and it drops the request at the end of the transfer. Each change of the ready flag latches a frame interrupt bit in the sender frame. The sender also has a per-channel acknowledge interrupt: it is latched when the receiver empties a channel, and it reaches the sender through the combined bit of the sender frame. Both frames report how many channels exist and carry a revision register.

Top module: `dbell_mbox`

## Requirements
- R1: A sender write to channel offset 0x0C ORs the written word into that channel's status. The status reads back at offset 0x00 of the channel window in either frame.
- R2: A receiver write to channel offset 0x08 clears every status bit written as 1. If a set and a clear reach the same channel in the same cycle, the set bits end up 1.
- R3: Receiver channel offset 0x14 sets mask bits, offset 0x18 clears them (set wins), and offset 0x10 reads the mask. Offset 0x04 reads status AND NOT mask.
- R4: `r_irq_chan` is high exactly when some channel's masked status is nonzero.
- R5: The combined words at byte 0xFA0 + 4*w report channel n at word n/32, bit n%32. In the receiver frame the bit means the channel's masked status is nonzero. In the sender frame it means the channel's acknowledge interrupt is pending and enabled.
- R6: Access request is at sender byte 0xF88 (bit 0, read/write) and access ready at 0xF8C (bit 0, read-only). Ready rises two cycles after the request is written to 1 and falls two cycles after it is written to 0.
- R7: In the sender frame interrupt status at 0xF90, bit 0 latches on a rise of ready and bit 1 latches on a fall of ready. Each stays set until a 1 is written to the same bit of 0xF94. `s_irq` is the OR over status AND enable, where the enable register is at 0xF98.
- R8: A sender channel's acknowledge bit (offset 0x10, bit 0) latches when that channel's status goes from nonzero to zero. Writing 1 to offset 0x14 clears it, and offset 0x18 bit 0 enables it. Bit 2 of the sender 0xF90 is the OR of the enabled, pending acknowledge bits.
- R9: Receiver 0xF90 bit 2 reads 1 when any masked status is nonzero. `r_irq_comb` is that bit AND bit 2 of the receiver enable register at 0xF98.
- R10: Byte 0xF80 of both frames reads the channel count (4 by default). Byte 0xFCC reads 0x11: major revision 1 in bits 7:4 and minor revision 1 in bits 3:0. With minor revision 0, bit 2 of the frame interrupt registers reads 0 and has no effect.
- R11: Reserved offsets, and channel windows at or beyond the channel count, read zero. Writes to them change no state.
- R12: Reset clears all status, mask, acknowledge, enable, request, ready and frame interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_wen | input | 1 | Sender write strobe |
| s_addr | input | 10 | Sender word address in frame |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data (combinational) |
| r_wen | input | 1 | Receiver write strobe |
| r_addr | input | 10 | Receiver word address in frame |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data (combinational) |
| s_irq | output | 1 | Sender frame interrupt |
| r_irq_chan | output | 1 | Receiver channel interrupt |
| r_irq_comb | output | 1 | Receiver combined-channel interrupt |

## Verification
The bench sweeps every channel with several overlapping set patterns. It then masks and clears them, so any mix-up of the set, clear and mask operations shows up as a wrong status word, a wrong masked word or a wrong combined bit. A set and a clear to the same channel in the same cycle catch a design that gives the clear priority, because the bits that are both set and cleared would read 0. The ready flag is sampled cycle by cycle after each request edge, which catches an off-by-one in the delay chain or an edge interrupt that latches on the wrong transition. Writes to a channel past the count and to reserved offsets are followed by reads of every real channel, which catches a decoder that aliases addresses into a live channel.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int MAX_CHAN   = 124;
  localparam int COMB_WORDS = 4;
  localparam int AW         = 10;

  // frame-level word addresses (byte offset / 4)
  localparam logic [AW-1:0] A_WIN_END = 10'h3E0;
  localparam logic [AW-1:0] A_CFG     = 10'h3E0;
  localparam logic [AW-1:0] A_REQ     = 10'h3E2;
  localparam logic [AW-1:0] A_RDY     = 10'h3E3;
  localparam logic [AW-1:0] A_IST     = 10'h3E4;
  localparam logic [AW-1:0] A_ICLR    = 10'h3E5;
  localparam logic [AW-1:0] A_IEN     = 10'h3E6;
  localparam logic [AW-1:0] A_COMB0   = 10'h3E8;
  localparam logic [AW-1:0] A_AIDR    = 10'h3F3;

  // word offsets inside a channel window
  localparam logic [2:0] SO_STAT = 3'd0;
  localparam logic [2:0] SO_SET  = 3'd3;
  localparam logic [2:0] SO_ACK  = 3'd4;
  localparam logic [2:0] SO_ACLR = 3'd5;
  localparam logic [2:0] SO_AEN  = 3'd6;
  localparam logic [2:0] RO_STAT = 3'd0;
  localparam logic [2:0] RO_MSKD = 3'd1;
  localparam logic [2:0] RO_CLR  = 3'd2;
  localparam logic [2:0] RO_MST  = 3'd4;
  localparam logic [2:0] RO_MSET = 3'd5;
  localparam logic [2:0] RO_MCLR = 3'd6;
endpackage

// File: rtl/dbell_chan.sv
module dbell_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic [DW-1:0] set_val,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_val,
  input  logic          mset_we,
  input  logic [DW-1:0] mset_val,
  input  logic          mclr_we,
  input  logic [DW-1:0] mclr_val,
  input  logic          aclr_we,
  input  logic          aen_we,
  input  logic          aen_val,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] masked,
  output logic          ack_st,
  output logic          ack_en
);
  logic [DW-1:0] stat_q, stat_n, mask_q, mask_n;
  logic          ack_q, ack_n, aen_q, aen_n;

  always_comb begin
    stat_n = stat_q;
    if (clr_we) stat_n = stat_n & ~clr_val;
    if (set_we) stat_n = stat_n | set_val;
    mask_n = mask_q;
    if (mclr_we) mask_n = mask_n & ~mclr_val;
    if (mset_we) mask_n = mask_n | mset_val;
    ack_n = ack_q;
    if (aclr_we) ack_n = 1'b0;
    if ((stat_q != '0) && (stat_n == '0)) ack_n = 1'b1;
    aen_n = aen_we ? aen_val : aen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      ack_q  <= 1'b0;
      aen_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
      ack_q  <= ack_n;
      aen_q  <= aen_n;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign masked = stat_q & ~mask_q;
  assign ack_st = ack_q;
  assign ack_en = aen_q;

  p_set_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((status & $past(set_val)) == $past(set_val)));
  p_clear_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((status & $past(clr_val)) == '0));
  p_ack_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) != '0 && status == '0) |-> ack_st);
endmodule

// File: rtl/dbell_hs.sv
module dbell_hs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_we,
  input  logic       req_val,
  input  logic       iclr_we,
  input  logic [1:0] iclr_val,
  output logic       req,
  output logic       ready,
  output logic [1:0] evt_st
);
  logic req_q, req_n, dly_q, rdy_q, rise, fall;
  logic [1:0] st_q, st_n;

  always_comb begin
    req_n = req_we ? req_val : req_q;
    rise  = dly_q & ~rdy_q;
    fall  = ~dly_q & rdy_q;
    st_n  = st_q;
    if (iclr_we) st_n = st_n & ~iclr_val;
    st_n  = st_n | {fall, rise};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      dly_q <= 1'b0;
      rdy_q <= 1'b0;
      st_q  <= 2'b00;
    end else begin
      req_q <= req_n;
      dly_q <= req_q;
      rdy_q <= dly_q;
      st_q  <= st_n;
    end
  end

  assign req    = req_q;
  assign ready  = rdy_q;
  assign evt_st = st_q;

  p_rise_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(req, 2));
  p_fall_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> !$past(req, 2));
  p_rise_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> evt_st[0]);
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox import dbell_pkg::*; #(
  parameter int NCH       = 4,
  parameter int MINOR_REV = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_wen,
  input  logic [AW-1:0] s_addr,
  input  logic [31:0]   s_wdata,
  output logic [31:0]   s_rdata,
  input  logic          r_wen,
  input  logic [AW-1:0] r_addr,
  input  logic [31:0]   r_wdata,
  output logic [31:0]   r_rdata,
  output logic          s_irq,
  output logic          r_irq_chan,
  output logic          r_irq_comb
);
  localparam logic [2:0]  IMASK = (MINOR_REV != 0) ? 3'b111 : 3'b011;
  localparam logic [31:0] AIDR  = {24'h0, 4'h1, 4'(MINOR_REV)};
  localparam int          CBITS = COMB_WORDS * 32;

  logic [6:0] s_idx, r_idx;
  logic [2:0] s_off, r_off;
  logic       s_chv, r_chv;

  assign s_idx = s_addr[9:3];
  assign s_off = s_addr[2:0];
  assign r_idx = r_addr[9:3];
  assign r_off = r_addr[2:0];
  assign s_chv = (s_addr < A_WIN_END) && (s_idx < 7'(NCH));
  assign r_chv = (r_addr < A_WIN_END) && (r_idx < 7'(NCH));

  logic [31:0]    stat [NCH];
  logic [31:0]    mask [NCH];
  logic [31:0]    mskd [NCH];
  logic [NCH-1:0] ack_st, ack_en, r_hit, s_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic s_sel, r_sel;
    assign s_sel = s_wen && s_chv && (s_idx == 7'(i));
    assign r_sel = r_wen && r_chv && (r_idx == 7'(i));
    dbell_chan #(.DW(32)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .set_we(s_sel && s_off == SO_SET),   .set_val(s_wdata),
      .clr_we(r_sel && r_off == RO_CLR),   .clr_val(r_wdata),
      .mset_we(r_sel && r_off == RO_MSET), .mset_val(r_wdata),
      .mclr_we(r_sel && r_off == RO_MCLR), .mclr_val(r_wdata),
      .aclr_we(s_sel && s_off == SO_ACLR && s_wdata[0]),
      .aen_we(s_sel && s_off == SO_AEN),   .aen_val(s_wdata[0]),
      .status(stat[i]), .mask(mask[i]), .masked(mskd[i]),
      .ack_st(ack_st[i]), .ack_en(ack_en[i])
    );
    assign r_hit[i] = (mskd[i] != '0);
    assign s_hit[i] = ack_st[i] & ack_en[i];
  end

  // handshake and edge interrupts
  logic       hs_req, hs_rdy;
  logic [1:0] hs_evt;
  dbell_hs u_hs (
    .clk(clk), .rst_n(rst_n),
    .req_we(s_wen && s_addr == A_REQ), .req_val(s_wdata[0]),
    .iclr_we(s_wen && s_addr == A_ICLR), .iclr_val(s_wdata[1:0]),
    .req(hs_req), .ready(hs_rdy), .evt_st(hs_evt)
  );

  // frame interrupt enables
  logic [2:0] s_ien_q, s_ien_n, r_ien_q, r_ien_n, s_ist, r_ist;
  always_comb begin
    s_ien_n = (s_wen && s_addr == A_IEN) ? (s_wdata[2:0] & IMASK) : s_ien_q;
    r_ien_n = (r_wen && r_addr == A_IEN) ? (r_wdata[2:0] & IMASK & 3'b100) : r_ien_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ien_q <= '0;
      r_ien_q <= '0;
    end else begin
      s_ien_q <= s_ien_n;
      r_ien_q <= r_ien_n;
    end
  end

  assign s_ist      = {|s_hit, hs_evt} & IMASK;
  assign r_ist      = {|r_hit, 2'b00} & IMASK;
  assign s_irq      = |(s_ist & s_ien_q);
  assign r_irq_chan = |r_hit;
  assign r_irq_comb = |(r_ist & r_ien_q);

  logic [CBITS-1:0] s_comb, r_comb;
  always_comb begin
    s_comb = '0;
    r_comb = '0;
    s_comb[NCH-1:0] = s_hit;
    r_comb[NCH-1:0] = r_hit;
  end

  // read muxes
  always_comb begin
    s_rdata = '0;
    if (s_chv) begin
      for (int i = 0; i < NCH; i++) begin
        if (s_idx == 7'(i)) begin
          case (s_off)
            SO_STAT: s_rdata = stat[i];
            SO_ACK:  s_rdata = {31'h0, ack_st[i]};
            SO_AEN:  s_rdata = {31'h0, ack_en[i]};
            default: s_rdata = '0;
          endcase
        end
      end
    end else if (s_addr[9:2] == A_COMB0[9:2]) begin
      s_rdata = s_comb[32*s_addr[1:0] +: 32];
    end else begin
      case (s_addr)
        A_CFG:   s_rdata = 32'(NCH);
        A_REQ:   s_rdata = {31'h0, hs_req};
        A_RDY:   s_rdata = {31'h0, hs_rdy};
        A_IST:   s_rdata = {29'h0, s_ist};
        A_IEN:   s_rdata = {29'h0, s_ien_q};
        A_AIDR:  s_rdata = AIDR;
        default: s_rdata = '0;
      endcase
    end
  end

  always_comb begin
    r_rdata = '0;
    if (r_chv) begin
      for (int i = 0; i < NCH; i++) begin
        if (r_idx == 7'(i)) begin
          case (r_off)
            RO_STAT: r_rdata = stat[i];
            RO_MSKD: r_rdata = mskd[i];
            RO_MST:  r_rdata = mask[i];
            default: r_rdata = '0;
          endcase
        end
      end
    end else if (r_addr[9:2] == A_COMB0[9:2]) begin
      r_rdata = r_comb[32*r_addr[1:0] +: 32];
    end else begin
      case (r_addr)
        A_CFG:   r_rdata = 32'(NCH);
        A_IST:   r_rdata = {29'h0, r_ist};
        A_IEN:   r_rdata = {29'h0, r_ien_q};
        A_AIDR:  r_rdata = AIDR;
        default: r_rdata = '0;
      endcase
    end
  end

  p_comb_implies_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    r_irq_comb |-> r_irq_chan);
  p_sirq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_irq |-> (s_ien_q != 3'b000));
  p_chan_irq_matches_comb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    r_irq_chan == (r_comb != '0));
endmodule

// File: tb/dbell_mbox_test.sv
`timescale 1ns/1ps
module dbell_mbox_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, s_wen, r_wen;
  logic [9:0]  s_addr, r_addr;
  logic [31:0] s_wdata, r_wdata, s_rdata, r_rdata;
  logic        s_irq, r_irq_chan, r_irq_comb;

  dbell_mbox #(.NCH(NCH), .MINOR_REV(1)) uut (
    .clk(clk), .rst_n(rst_n),
    .s_wen(s_wen), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .r_wen(r_wen), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .s_irq(s_irq), .r_irq_chan(r_irq_chan), .r_irq_comb(r_irq_comb)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] est [NCH];
  logic [31:0] emk [NCH];
  logic [31:0] v;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic swr(input int ba, input logic [31:0] d);
    @(negedge clk); s_wen = 1'b1; s_addr = 10'(ba >> 2); s_wdata = d;
    @(negedge clk); s_wen = 1'b0;
  endtask

  task automatic rwr(input int ba, input logic [31:0] d);
    @(negedge clk); r_wen = 1'b1; r_addr = 10'(ba >> 2); r_wdata = d;
    @(negedge clk); r_wen = 1'b0;
  endtask

  task automatic srd(input int ba, output logic [31:0] d);
    @(negedge clk); s_addr = 10'(ba >> 2); #1; d = s_rdata;
  endtask

  task automatic rrd(input int ba, output logic [31:0] d);
    @(negedge clk); r_addr = 10'(ba >> 2); #1; d = r_rdata;
  endtask

  function automatic logic any_masked();
    logic a = 1'b0;
    for (int c = 0; c < NCH; c++) a |= ((est[c] & ~emk[c]) != 0);
    return a;
  endfunction

  task automatic check_all_chan(input string rq);
    for (int c = 0; c < NCH; c++) begin
      srd(c*32, v);      chk(rq, v, est[c]);
      rrd(c*32, v);      chk(rq, v, est[c]);
      rrd(c*32 + 4, v);  chk(rq, v, est[c] & ~emk[c]);
      rrd(c*32 + 16, v); chk(rq, v, emk[c]);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] cw;
    rst_n = 1'b0; s_wen = 1'b0; r_wen = 1'b0;
    s_addr = '0; r_addr = '0; s_wdata = '0; r_wdata = '0;
    for (int c = 0; c < NCH; c++) begin est[c] = '0; emk[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R12 reset state
    check_all_chan("R12");
    srd(32'hF8C, v); chk("R12", v, 0);
    srd(32'hF90, v); chk("R12", v, 0);
    chk("R12", {29'h0, s_irq, r_irq_chan, r_irq_comb}, 0);

    // R10 identification
    srd(32'hF80, v); chk("R10", v, NCH);
    rrd(32'hF80, v); chk("R10", v, NCH);
    srd(32'hFCC, v); chk("R10", v, 32'h11);
    rrd(32'hFCC, v); chk("R10", v, 32'h11);

    // R1 set sweep with overlapping patterns
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [31:0] pat;
        pat = (32'h1 << ((c*7 + p*3) % 32)) | (32'h8000_0000 >> (c + p));
        swr(c*32 + 12, pat);
        est[c] = est[c] | pat;
      end
      check_all_chan("R1");
    end
    chk("R4", {31'h0, r_irq_chan}, {31'h0, any_masked()});

    // R3 masking; channel 3 fully masked
    for (int c = 0; c < NCH; c++) begin
      emk[c] = (c == 3) ? est[c] : (est[c] & 32'h0F0F_0F0F);
      rwr(c*32 + 20, emk[c]);
    end
    check_all_chan("R3");
    chk("R4", {31'h0, r_irq_chan}, {31'h0, any_masked()});
    // R5 combined word: channel 3 masked out
    cw = '0;
    for (int c = 0; c < NCH; c++) cw[c] = ((est[c] & ~emk[c]) != 0);
    rrd(32'hFA0, v); chk("R5", v, cw);
    chk("R5", cw, 32'h7);
    rrd(32'hFA4, v); chk("R5", v, 0);
    // mask clear on channel 3
    rwr(3*32 + 24, 32'h0000_FFFF);
    emk[3] = emk[3] & 32'hFFFF_0000;
    check_all_chan("R3");
    cw[3] = ((est[3] & ~emk[3]) != 0);
    rrd(32'hFA0, v); chk("R5", v, cw);

    // R9 combined receiver interrupt
    chk("R9", {31'h0, r_irq_comb}, 0);
    rrd(32'hF90, v); chk("R9", v, any_masked() ? 32'h4 : 32'h0);
    rwr(32'hF98, 32'h4);
    chk("R9", {31'h0, r_irq_comb}, {31'h0, any_masked()});

    // R2 clear and set priority
    rwr(32 + 8, 32'hFFFF_0000);
    est[1] = est[1] & 32'h0000_FFFF;
    check_all_chan("R2");
    @(negedge clk);
    s_wen = 1'b1; s_addr = 10'(12 >> 2); s_wdata = 32'h0000_0011;
    r_wen = 1'b1; r_addr = 10'(8 >> 2);  r_wdata = 32'h0000_0033;
    @(negedge clk); s_wen = 1'b0; r_wen = 1'b0;
    est[0] = (est[0] & ~32'h33) | 32'h11;
    srd(0, v); chk("R2", v, est[0]);
    chk("R2", v & 32'h11, 32'h11);

    // R8 acknowledge interrupt on channel 2
    srd(2*32 + 16, v); chk("R8", v, 0);
    swr(2*32 + 24, 1);
    rwr(2*32 + 8, 32'hFFFF_FFFF);
    est[2] = '0;
    srd(2*32 + 16, v); chk("R8", v, 1);
    srd(32'hFA0, v);   chk("R8", v, 32'h4);
    srd(32'hF90, v);   chk("R8", v, 32'h4);
    chk("R8", {31'h0, s_irq}, 0);
    swr(32'hF98, 32'h4);
    chk("R8", {31'h0, s_irq}, 1);
    swr(2*32 + 20, 1);
    srd(2*32 + 16, v); chk("R8", v, 0);
    chk("R8", {31'h0, s_irq}, 0);

    // R6 ready follows request by two cycles
    @(negedge clk); s_wen = 1'b1; s_addr = 10'(32'hF88 >> 2); s_wdata = 1;
    @(negedge clk); s_wen = 1'b0; s_addr = 10'(32'hF8C >> 2); #1;
    chk("R6", s_rdata, 0);
    @(negedge clk); #1; chk("R6", s_rdata, 0);
    @(negedge clk); #1; chk("R6", s_rdata, 1);
    srd(32'hF88, v); chk("R6", v, 1);
    // R7 rise latch, enable gating
    srd(32'hF90, v); chk("R7", v, 1);
    chk("R7", {31'h0, s_irq}, 0);
    swr(32'hF98, 32'h7);
    chk("R7", {31'h0, s_irq}, 1);
    @(negedge clk); s_wen = 1'b1; s_addr = 10'(32'hF88 >> 2); s_wdata = 0;
    @(negedge clk); s_wen = 1'b0; s_addr = 10'(32'hF8C >> 2); #1;
    chk("R6", s_rdata, 1);
    @(negedge clk); #1; chk("R6", s_rdata, 1);
    @(negedge clk); #1; chk("R6", s_rdata, 0);
    srd(32'hF90, v); chk("R7", v, 3);
    swr(32'hF94, 32'h1);
    srd(32'hF90, v); chk("R7", v, 2);
    chk("R7", {31'h0, s_irq}, 1);
    swr(32'hF94, 32'h2);
    srd(32'hF90, v); chk("R7", v, 0);
    chk("R7", {31'h0, s_irq}, 0);

    // R11 reserved and out-of-range locations
    srd(4, v);          chk("R11", v, 0);
    srd(5*32, v);       chk("R11", v, 0);
    rrd(NCH*32, v);     chk("R11", v, 0);
    rrd(32'hF84, v);    chk("R11", v, 0);
    srd(32'hF9C, v);    chk("R11", v, 0);
    swr(NCH*32 + 12, 32'hFFFF_FFFF);
    swr(4, 32'hFFFF_FFFF);
    swr(28, 32'hFFFF_FFFF);
    rwr(12, 32'hFFFF_FFFF);
    rwr(NCH*32 + 8, 32'hFFFF_FFFF);
    check_all_chan("R11");
    srd(NCH*32, v);     chk("R11", v, 0);

    // R12 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) begin est[c] = '0; emk[c] = '0; end
    check_all_chan("R12");
    srd(32'hF88, v); chk("R12", v, 0);
    srd(32'hF98, v); chk("R12", v, 0);
    rrd(32'hF98, v); chk("R12", v, 0);
    chk("R12", {29'h0, s_irq, r_irq_chan, r_irq_comb}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule